// File: doc/BRIEF.md
# Integer ALU Execute Stage

This block is the integer execute step of a 32-bit, three-operand RISC pipeline. Each cycle in which `valid_i` is high, it takes an instruction word and the two register operand values the register file has already read. It decodes the 6-bit major opcode in bits 31..26. It picks the second operand from either the register input or the 16-bit immediate in bits 15..0, which it extends in the way that opcode requires. It then computes a 32-bit result. One clock later it presents the result together with the destination register index and a write-enable for the register file.

The stage covers add, subtract and multiply (all keeping the low 32 bits), the five bitwise logic functions, six compares that produce a boolean word, three shift kinds, and byte or halfword sign extension. Every other opcode is flagged as illegal and never writes. This includes unsigned divide and modulus, which are not carried out here, as well as loads, stores, branches and control-register access. The upstream pipeline or trap logic is expected to act on that flag.

Top module: `alu_exec_stage`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `we_o` and `illegal_o` are 0 and `result_o` and `rd_o` are 0.
- R2: All outputs are registered with one cycle of latency: `valid_o` equals `valid_i` of the previous cycle, and when `valid_o` is 0 both `we_o` and `illegal_o` are 0.
- R3: Opcodes with bit 31 set (values 32..63) are register-register forms. They take the second operand from `opb_i` and name the destination in bits 15..11. Opcodes 0..31 are register-immediate forms. They use the immediate in bits 15..0 and name the destination in bits 20..16.
- R4: Add-immediate (13), multiply-immediate (2), compare-equal-immediate (25), compare-not-equal-immediate (31), signed compare-greater-immediate (26) and signed compare-greater-or-equal-immediate (27) sign-extend the immediate from bit 15.
- R5: And-immediate (8), or-immediate (14), xor-immediate (6), nor-immediate (1), xnor-immediate (9), unsigned compare-greater-immediate (29) and unsigned compare-greater-or-equal-immediate (28) zero-extend the immediate.
- R6: And-high (24) and or-high (30) place the immediate in bits 31..16 with zeros below before applying the logic function.
- R7: Add (45), subtract (50) and multiply (34), together with their immediate forms, return the low 32 bits of the two's-complement result.
- R8: And (40), or (46), xor (38), nor (33) and xnor (41) return the bitwise function of the two operands.
- R9: Compares return 1 when the condition holds and 0 otherwise. The register opcodes are: equal 57, not-equal 63, signed greater 58, signed greater-or-equal 59, unsigned greater 61, unsigned greater-or-equal 60.
- R10: Shifts use only the low 5 bits of the shift operand. Left shift (47, 15) fills with zeros. Arithmetic right shift (37, 5) replicates bit 31. Logical right shift (32, 0) fills with zeros.
- R11: Sign-extend-byte (44) copies bit 7 of `opa_i` into bits 31..8. Sign-extend-halfword (55) copies bit 15 into bits 31..16.
- R12: A destination index of 0 forces `we_o` low, although the result is still produced.
- R13: Any opcode outside R4..R11, including divide (35) and modulus (49), sets `illegal_o`, keeps `we_o` low and gives a `result_o` of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | First register operand value |
| opb_i | input | 32 | Second register operand value |
| valid_o | output | 1 | Registered copy of valid_i |
| result_o | output | 32 | Computed result |
| rd_o | output | 5 | Destination register index |
| we_o | output | 1 | Register file write-enable |
| illegal_o | output | 1 | Opcode is not executed by this stage |

## Verification
Random operands mixed with the values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF are run through every executed opcode, plus random opcodes. This separates signed from unsigned compares and arithmetic from logical right shifts, since those pairs only disagree when bit 31 is set. Immediates with bit 15 set tell sign extension apart from zero extension and from the high-half placement. Shift amounts of 32 and above show whether only the low 5 bits are used. Register fields holding distinct values expose a destination taken from the wrong field, and destination 0 together with divide, modulus and load opcodes probes write suppression.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int unsigned OPC_W = 6;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned REG_W = 5;

  localparam logic [OPC_W-1:0] OPC_ADD     = 6'd45;
  localparam logic [OPC_W-1:0] OPC_ADDI    = 6'd13;
  localparam logic [OPC_W-1:0] OPC_SUB     = 6'd50;
  localparam logic [OPC_W-1:0] OPC_MUL     = 6'd34;
  localparam logic [OPC_W-1:0] OPC_MULI    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_AND     = 6'd40;
  localparam logic [OPC_W-1:0] OPC_ANDI    = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ANDHI   = 6'd24;
  localparam logic [OPC_W-1:0] OPC_OR      = 6'd46;
  localparam logic [OPC_W-1:0] OPC_ORI     = 6'd14;
  localparam logic [OPC_W-1:0] OPC_ORHI    = 6'd30;
  localparam logic [OPC_W-1:0] OPC_XOR     = 6'd38;
  localparam logic [OPC_W-1:0] OPC_XORI    = 6'd6;
  localparam logic [OPC_W-1:0] OPC_NOR     = 6'd33;
  localparam logic [OPC_W-1:0] OPC_NORI    = 6'd1;
  localparam logic [OPC_W-1:0] OPC_XNOR    = 6'd41;
  localparam logic [OPC_W-1:0] OPC_XNORI   = 6'd9;
  localparam logic [OPC_W-1:0] OPC_SL      = 6'd47;
  localparam logic [OPC_W-1:0] OPC_SLI     = 6'd15;
  localparam logic [OPC_W-1:0] OPC_SR      = 6'd37;
  localparam logic [OPC_W-1:0] OPC_SRI     = 6'd5;
  localparam logic [OPC_W-1:0] OPC_SRU     = 6'd32;
  localparam logic [OPC_W-1:0] OPC_SRUI    = 6'd0;
  localparam logic [OPC_W-1:0] OPC_CEQ     = 6'd57;
  localparam logic [OPC_W-1:0] OPC_CEQI    = 6'd25;
  localparam logic [OPC_W-1:0] OPC_CNE     = 6'd63;
  localparam logic [OPC_W-1:0] OPC_CNEI    = 6'd31;
  localparam logic [OPC_W-1:0] OPC_CGT     = 6'd58;
  localparam logic [OPC_W-1:0] OPC_CGTI    = 6'd26;
  localparam logic [OPC_W-1:0] OPC_CGE     = 6'd59;
  localparam logic [OPC_W-1:0] OPC_CGEI    = 6'd27;
  localparam logic [OPC_W-1:0] OPC_CGTU    = 6'd61;
  localparam logic [OPC_W-1:0] OPC_CGTUI   = 6'd29;
  localparam logic [OPC_W-1:0] OPC_CGEU    = 6'd60;
  localparam logic [OPC_W-1:0] OPC_CGEUI   = 6'd28;
  localparam logic [OPC_W-1:0] OPC_SEXT8   = 6'd44;
  localparam logic [OPC_W-1:0] OPC_SEXT16  = 6'd55;

  typedef enum logic [4:0] {
    FN_ADD, FN_SUB, FN_MUL,
    FN_AND, FN_OR, FN_XOR, FN_NOR, FN_XNOR,
    FN_SLL, FN_SRA, FN_SRL,
    FN_CEQ, FN_CNE, FN_CGT, FN_CGE, FN_CGTU, FN_CGEU,
    FN_SEXT8, FN_SEXT16
  } alu_fn_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_HIGH
  } imm_ext_e;

  typedef struct packed {
    alu_fn_e  fn;
    imm_ext_e ext;
    logic     use_imm;
    logic     legal;
  } alu_dec_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
  import alu_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output alu_dec_t         dec_o
);

  always_comb begin
    dec_o.fn      = FN_ADD;
    dec_o.ext     = IMM_SIGN;
    dec_o.use_imm = ~opcode_i[OPC_W-1];  // low half of opcode space is immediate form
    dec_o.legal   = 1'b1;
    case (opcode_i)
      OPC_ADD, OPC_ADDI:   dec_o.fn = FN_ADD;
      OPC_SUB:             dec_o.fn = FN_SUB;
      OPC_MUL, OPC_MULI:   dec_o.fn = FN_MUL;
      OPC_AND:             dec_o.fn = FN_AND;
      OPC_ANDI:  begin dec_o.fn = FN_AND;  dec_o.ext = IMM_ZERO; end
      OPC_ANDHI: begin dec_o.fn = FN_AND;  dec_o.ext = IMM_HIGH; end
      OPC_OR:              dec_o.fn = FN_OR;
      OPC_ORI:   begin dec_o.fn = FN_OR;   dec_o.ext = IMM_ZERO; end
      OPC_ORHI:  begin dec_o.fn = FN_OR;   dec_o.ext = IMM_HIGH; end
      OPC_XOR:             dec_o.fn = FN_XOR;
      OPC_XORI:  begin dec_o.fn = FN_XOR;  dec_o.ext = IMM_ZERO; end
      OPC_NOR:             dec_o.fn = FN_NOR;
      OPC_NORI:  begin dec_o.fn = FN_NOR;  dec_o.ext = IMM_ZERO; end
      OPC_XNOR:            dec_o.fn = FN_XNOR;
      OPC_XNORI: begin dec_o.fn = FN_XNOR; dec_o.ext = IMM_ZERO; end
      OPC_SL, OPC_SLI:     dec_o.fn = FN_SLL;
      OPC_SR, OPC_SRI:     dec_o.fn = FN_SRA;
      OPC_SRU, OPC_SRUI:   dec_o.fn = FN_SRL;
      OPC_CEQ, OPC_CEQI:   dec_o.fn = FN_CEQ;
      OPC_CNE, OPC_CNEI:   dec_o.fn = FN_CNE;
      OPC_CGT, OPC_CGTI:   dec_o.fn = FN_CGT;
      OPC_CGE, OPC_CGEI:   dec_o.fn = FN_CGE;
      OPC_CGTU:            dec_o.fn = FN_CGTU;
      OPC_CGTUI: begin dec_o.fn = FN_CGTU; dec_o.ext = IMM_ZERO; end
      OPC_CGEU:            dec_o.fn = FN_CGEU;
      OPC_CGEUI: begin dec_o.fn = FN_CGEU; dec_o.ext = IMM_ZERO; end
      OPC_SEXT8:           dec_o.fn = FN_SEXT8;
      OPC_SEXT16:          dec_o.fn = FN_SEXT16;
      default:             dec_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_exec_operand.sv
module alu_exec_operand
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              use_imm_i,
  input  imm_ext_e          ext_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] opnd_o
);

  localparam int unsigned PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    case (ext_i)
      IMM_SIGN: imm_ext = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
      IMM_ZERO: imm_ext = {{PAD_W{1'b0}}, imm_i};
      IMM_HIGH: imm_ext = {{PAD_W{1'b0}}, imm_i} << IMM_W;
      default:  imm_ext = '0;
    endcase
  end

  assign opnd_o = use_imm_i ? imm_ext : reg_i;

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o
);

  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] shamt;
  logic               flag;

  assign shamt = b_i[SHAMT_W-1:0];

  always_comb begin
    case (fn_i)
      FN_CEQ:  flag = (a_i == b_i);
      FN_CNE:  flag = (a_i != b_i);
      FN_CGT:  flag = ($signed(a_i) >  $signed(b_i));
      FN_CGE:  flag = ($signed(a_i) >= $signed(b_i));
      FN_CGTU: flag = (a_i >  b_i);
      FN_CGEU: flag = (a_i >= b_i);
      default: flag = 1'b0;
    endcase
  end

  always_comb begin
    case (fn_i)
      FN_ADD:    result_o = a_i + b_i;
      FN_SUB:    result_o = a_i - b_i;
      FN_MUL:    result_o = a_i * b_i;
      FN_AND:    result_o = a_i & b_i;
      FN_OR:     result_o = a_i | b_i;
      FN_XOR:    result_o = a_i ^ b_i;
      FN_NOR:    result_o = ~(a_i | b_i);
      FN_XNOR:   result_o = ~(a_i ^ b_i);
      FN_SLL:    result_o = a_i << shamt;
      FN_SRA:    result_o = $unsigned($signed(a_i) >>> shamt);
      FN_SRL:    result_o = a_i >> shamt;
      FN_SEXT8:  result_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
      FN_SEXT16: result_o = {{(DATA_W-16){a_i[15]}}, a_i[15:0]};
      FN_CEQ, FN_CNE, FN_CGT, FN_CGE, FN_CGTU, FN_CGEU:
                 result_o = {{(DATA_W-1){1'b0}}, flag};
      default:   result_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [REG_W-1:0]  rd_o,
  output logic              we_o,
  output logic              illegal_o
);

  localparam int unsigned OPC_LSB = INSN_W - OPC_W;
  localparam int unsigned RI_LSB  = OPC_LSB - 2*REG_W;  // imm-form destination
  localparam int unsigned RR_LSB  = OPC_LSB - 3*REG_W;  // reg-form destination

  alu_dec_t          dec;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;
  logic [REG_W-1:0]  rd_sel;
  logic              we_next;

  alu_exec_decode u_decode (
    .opcode_i (insn_i[INSN_W-1:OPC_LSB]),
    .dec_o    (dec)
  );

  alu_exec_operand #(.DATA_W(DATA_W)) u_operand (
    .use_imm_i (dec.use_imm),
    .ext_i     (dec.ext),
    .imm_i     (insn_i[IMM_W-1:0]),
    .reg_i     (opb_i),
    .opnd_o    (opnd_b)
  );

  alu_exec_core #(.DATA_W(DATA_W)) u_core (
    .fn_i     (dec.fn),
    .a_i      (opa_i),
    .b_i      (opnd_b),
    .result_o (alu_res)
  );

  assign rd_sel  = insn_i[INSN_W-1] ? insn_i[RR_LSB +: REG_W] : insn_i[RI_LSB +: REG_W];
  assign we_next = dec.legal && (rd_sel != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      rd_o      <= '0;
      we_o      <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= dec.legal ? alu_res : '0;
        rd_o      <= rd_sel;
        we_o      <= we_next;
        illegal_o <= ~dec.legal;
      end else begin
        we_o      <= 1'b0;
        illegal_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/alu_exec_stage_chk.sv
module alu_exec_stage_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INSN_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [INSN_W-1:0] insn_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [4:0]        rd_o,
  input logic              we_o,
  input logic              illegal_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!valid_o && !we_o && !illegal_o && result_o == '0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r2_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!we_o && !illegal_o));

  a_r3_rr_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[31]) |=> (rd_o == $past(insn_i[15:11])));

  a_r3_ri_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !insn_i[31]) |=> (rd_o == $past(insn_i[20:16])));

  a_r9_boolean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (insn_i[31:26] inside {6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd31,
                                       6'd57, 6'd58, 6'd59, 6'd60, 6'd61, 6'd63}))
    |=> (result_o[DATA_W-1:1] == '0));

  a_r12_no_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (rd_o != '0));

  a_r13_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!we_o && result_o == '0));

  a_r13_divide_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (insn_i[31:26] == 6'd35 || insn_i[31:26] == 6'd49)) |=> illegal_o);

endmodule

bind alu_exec_stage alu_exec_stage_chk #(.DATA_W(DATA_W), .INSN_W(INSN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .rd_o      (rd_o),
  .we_o      (we_o),
  .illegal_o (illegal_o)
);

// File: tb/alu_exec_stage_bench.sv
module alu_exec_stage_bench;

  localparam int unsigned WATCHDOG = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [4:0]  rd_o;
  logic        we_o;
  logic        illegal_o;

  int checks = 0;
  int failures = 0;

  localparam logic [5:0] EXEC_OPS [37] = '{
    6'd45, 6'd13, 6'd50, 6'd34, 6'd2, 6'd40, 6'd8, 6'd24, 6'd46, 6'd14,
    6'd30, 6'd38, 6'd6, 6'd33, 6'd1, 6'd41, 6'd9, 6'd47, 6'd15, 6'd37,
    6'd5, 6'd32, 6'd0, 6'd57, 6'd25, 6'd58, 6'd26, 6'd59, 6'd27, 6'd60,
    6'd28, 6'd61, 6'd29, 6'd63, 6'd31, 6'd44, 6'd55
  };

  always #4 clk_i = ~clk_i;

  alu_exec_stage u_alu_exec_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .insn_i    (insn_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .rd_o      (rd_o),
    .we_o      (we_o),
    .illegal_o (illegal_o)
  );

  function automatic void model(input logic [31:0] insn, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] res,
                                output logic [4:0] rd, output logic we,
                                output logic ill);
    logic [5:0]  op;
    logic [15:0] imm;
    logic [31:0] sx, zx, hx;
    op  = insn[31:26];
    imm = insn[15:0];
    sx  = {{16{imm[15]}}, imm};
    zx  = {16'h0, imm};
    hx  = {imm, 16'h0};
    ill = 1'b0;
    res = '0;
    case (op)
      6'd45: res = a + b;
      6'd13: res = a + sx;
      6'd50: res = a - b;
      6'd34: res = a * b;
      6'd2:  res = a * sx;
      6'd40: res = a & b;
      6'd8:  res = a & zx;
      6'd24: res = a & hx;
      6'd46: res = a | b;
      6'd14: res = a | zx;
      6'd30: res = a | hx;
      6'd38: res = a ^ b;
      6'd6:  res = a ^ zx;
      6'd33: res = ~(a | b);
      6'd1:  res = ~(a | zx);
      6'd41: res = ~(a ^ b);
      6'd9:  res = ~(a ^ zx);
      6'd47: res = a << b[4:0];
      6'd15: res = a << imm[4:0];
      6'd37: res = $unsigned($signed(a) >>> b[4:0]);
      6'd5:  res = $unsigned($signed(a) >>> imm[4:0]);
      6'd32: res = a >> b[4:0];
      6'd0:  res = a >> imm[4:0];
      6'd57: res = 32'(a == b);
      6'd25: res = 32'(a == sx);
      6'd63: res = 32'(a != b);
      6'd31: res = 32'(a != sx);
      6'd58: res = 32'($signed(a) > $signed(b));
      6'd26: res = 32'($signed(a) > $signed(sx));
      6'd59: res = 32'($signed(a) >= $signed(b));
      6'd27: res = 32'($signed(a) >= $signed(sx));
      6'd61: res = 32'(a > b);
      6'd29: res = 32'(a > zx);
      6'd60: res = 32'(a >= b);
      6'd28: res = 32'(a >= zx);
      6'd44: res = {{24{a[7]}}, a[7:0]};
      6'd55: res = {{16{a[15]}}, a[15:0]};
      default: ill = 1'b1;
    endcase
    rd = op[5] ? insn[15:11] : insn[20:16];
    we = !ill && (rd != 5'd0);
  endfunction

  function automatic logic [31:0] enc_rr(input logic [5:0] op, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic [4:0] rd);
    return {op, ra, rb, rd, 11'h0};
  endfunction

  function automatic logic [31:0] enc_ri(input logic [5:0] op, input logic [4:0] ra,
                                         input logic [4:0] rd, input logic [15:0] imm);
    return {op, ra, rd, imm};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, output registered at the next rising edge, sample at the falling edge after
  task automatic run(input string tag, input logic [31:0] insn,
                     input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic [4:0]  ed;
    logic        ew, ei;
    model(insn, a, b, er, ed, ew, ei);
    valid_i = 1'b1;
    insn_i  = insn;
    opa_i   = a;
    opb_i   = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(tag, "valid_o", 32'(valid_o), 32'd1);
    check(tag, "result_o", result_o, er);
    check(tag, "rd_o", 32'(rd_o), 32'(ed));
    check(tag, "we_o", 32'(we_o), 32'(ew));
    check(tag, "illegal_o", 32'(illegal_o), 32'(ei));
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(WATCHDOG * 8);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in reset
    check("R1", "valid_o", 32'(valid_o), 32'd0);
    check("R1", "we_o", 32'(we_o), 32'd0);
    check("R1", "illegal_o", 32'(illegal_o), 32'd0);
    check("R1", "result_o", result_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: idle cycle produces no valid or write
    @(negedge clk_i);
    check("R2", "valid_o idle", 32'(valid_o), 32'd0);
    check("R2", "we_o idle", 32'(we_o), 32'd0);

    // R3: destination field and operand source per form
    run("R3", enc_rr(6'd45, 5'd1, 5'd2, 5'd3), 32'd10, 32'd20);
    run("R3", enc_ri(6'd13, 5'd1, 5'd9, 16'h0005), 32'd10, 32'd999);
    // R4: sign extension
    run("R4", enc_ri(6'd13, 5'd0, 5'd4, 16'hFFFF), 32'd5, 32'd0);
    run("R4", enc_ri(6'd2, 5'd0, 5'd4, 16'hFFFE), 32'd7, 32'd0);
    run("R4", enc_ri(6'd25, 5'd0, 5'd4, 16'hFFFF), 32'hFFFF_FFFF, 32'd0);
    // R5: zero extension
    run("R5", enc_ri(6'd14, 5'd0, 5'd4, 16'h8000), 32'd0, 32'd0);
    run("R5", enc_ri(6'd28, 5'd0, 5'd4, 16'hFFFF), 32'd0, 32'd0);
    run("R5", enc_ri(6'd9, 5'd0, 5'd4, 16'h00F0), 32'h0000_00FF, 32'd0);
    // R6: high half placement
    run("R6", enc_ri(6'd30, 5'd0, 5'd4, 16'hABCD), 32'h0000_1234, 32'd0);
    run("R6", enc_ri(6'd24, 5'd0, 5'd4, 16'hFF00), 32'hFFFF_FFFF, 32'd0);
    // R7: wraparound arithmetic
    run("R7", enc_rr(6'd45, 5'd0, 5'd0, 5'd5), 32'hFFFF_FFFF, 32'd1);
    run("R7", enc_rr(6'd50, 5'd0, 5'd0, 5'd5), 32'd0, 32'd1);
    run("R7", enc_rr(6'd34, 5'd0, 5'd0, 5'd5), 32'h0001_0001, 32'h0001_0001);
    // R8: logic
    run("R8", enc_rr(6'd33, 5'd0, 5'd0, 5'd6), 32'hF0F0_0000, 32'h0000_0F0F);
    run("R8", enc_rr(6'd41, 5'd0, 5'd0, 5'd6), 32'h1234_5678, 32'h1234_5678);
    // R9: signed versus unsigned compares
    run("R9", enc_rr(6'd58, 5'd0, 5'd0, 5'd7), 32'h8000_0000, 32'd1);
    run("R9", enc_rr(6'd61, 5'd0, 5'd0, 5'd7), 32'h8000_0000, 32'd1);
    run("R9", enc_rr(6'd59, 5'd0, 5'd0, 5'd7), 32'd3, 32'd3);
    run("R9", enc_ri(6'd27, 5'd0, 5'd7, 16'hFFFF), 32'd0, 32'd0);
    // R10: shift amount uses low 5 bits only
    run("R10", enc_rr(6'd37, 5'd0, 5'd0, 5'd8), 32'h8000_0000, 32'd33);
    run("R10", enc_rr(6'd32, 5'd0, 5'd0, 5'd8), 32'h8000_0000, 32'd33);
    run("R10", enc_rr(6'd47, 5'd0, 5'd0, 5'd8), 32'h0000_0003, 32'd32);
    run("R10", enc_ri(6'd5, 5'd0, 5'd8, 16'h0024), 32'h8000_0000, 32'd0);
    // R11: sign extension of byte and halfword
    run("R11", enc_rr(6'd44, 5'd0, 5'd0, 5'd9), 32'h1234_5680, 32'd0);
    run("R11", enc_rr(6'd55, 5'd0, 5'd0, 5'd9), 32'hFFFF_7FFF, 32'd0);
    // R12: destination zero
    run("R12", enc_rr(6'd45, 5'd0, 5'd0, 5'd0), 32'd1, 32'd2);
    run("R12", enc_ri(6'd13, 5'd3, 5'd0, 16'h0001), 32'd1, 32'd0);
    // R13: unsupported opcodes
    run("R13", enc_rr(6'd35, 5'd0, 5'd0, 5'd10), 32'd9, 32'd3);
    run("R13", enc_rr(6'd49, 5'd0, 5'd0, 5'd10), 32'd9, 32'd3);
    run("R13", enc_ri(6'd10, 5'd0, 5'd10, 16'h0004), 32'd9, 32'd3);

    // random mix; R3 destination and operand routing across all opcodes
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      if ($urandom_range(0, 9) < 8) op = EXEC_OPS[$urandom_range(0, 36)];
      else op = 6'($urandom());
      run("R3", {op, 26'($urandom())}, pick_val(), pick_val());
    end

    @(negedge clk_i);
    check("R2", "valid_o after burst", 32'(valid_o), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule